// File: doc/BRIEF.md
# Serial-to-TDM Timeslot Inserter

This block takes a user serial bit stream arriving on an interface clock and places it into a contiguous run of timeslots of a T1-sized (24 slot) or E1-sized (32 slot) TDM frame. The frame runs on a separate multiplexer bit clock. Configuration pins select the frame size, the first timeslot, and the user rate. The rate is either N×64 kbps, which fills N whole slots, or 56 kbps, which fills seven bits of one slot. A dual-clock FIFO with Gray-coded pointers carries the bits across the clock boundary.

User bits are taken on a valid/ready handshake. A bit is consumed in the cycle where `in_valid` and `in_ready` are both high. `in_ready` drops while the FIFO is full. A source that holds `in_valid` with `in_ready` low must keep `in_bit` unchanged. The TDM side places no user data on the line until the FIFO has reached half its depth, so that a source running at the line rate cannot run the line dry.

In 56 kbps mode, the eighth bit of the slot can carry an identification word: an address byte followed by a security byte, one bit per frame. Positions that carry no user data or marker data are sent as ones. Frame alignment patterns and line coding are handled elsewhere.

Top module: `s2t_inserter`

## Requirements
- R1: Each frame is 8×24 bits in T1 mode (`cfg_e1`=0) and 8×32 bits in E1 mode (`cfg_e1`=1). Each slot is sent MSB first, one bit per `tdm_clk`. `tdm_fs` is high exactly with bit 0 of slot 0 and low at every other position.
- R2: In N×64 mode (`cfg_rate56`=0), slots `cfg_start` through `cfg_start`+`cfg_nslots`-1 carry user bits. All eight bits of each of these slots are user bits, sent in arrival order.
- R3: Every bit position that is neither a user position nor a marker position is driven to 1. `tdm_data` is 1 and `tdm_fs` is 0 while `tdm_rst_n` is low.
- R4: In E1 mode, slot 0 never carries user data. A start slot of 0 in E1 mode is a configuration error.
- R5: `cfg_err` is 1 in each of these cases: the start slot plus the span exceeds the frame's slot count; N×64 mode is selected with `cfg_nslots`=0; or rule R4 is broken. The span is 1 in 56 kbps mode and `cfg_nslots` otherwise. While `cfg_err` is 1, every output bit is 1.
- R6: In 56 kbps mode (`cfg_rate56`=1), bits 0 to 6 of slot `cfg_start` carry user bits in arrival order. Bit 7 of that slot is the marker position. With `cfg_addr_en`=0, the marker position is 1.
- R7: With `cfg_addr_en`=1 in 56 kbps mode, the marker bit of frame k carries bit 15-(k mod 16) of the word {`cfg_addr`,`cfg_sec`}. Frames are counted from 0 at the first frame after reset.
- R8: No user bit is sent before the FIFO has held at least DEPTH/2 bits. Until then, user positions carry 1.
- R9: `in_ready` is low only when the FIFO holds DEPTH bits. Every accepted bit is sent exactly once and in order, with no loss and no duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| if_clk | input | 1 | Interface clock |
| if_rst_n | input | 1 | Active-low async reset, interface domain |
| in_valid | input | 1 | User bit present |
| in_ready | output | 1 | FIFO can take a bit |
| in_bit | input | 1 | User data bit |
| tdm_clk | input | 1 | TDM bit clock |
| tdm_rst_n | input | 1 | Active-low async reset, TDM domain |
| cfg_e1 | input | 1 | 1 = 32-slot frame, 0 = 24-slot frame |
| cfg_rate56 | input | 1 | 1 = 56 kbps mode, 0 = N×64 |
| cfg_start | input | 5 | First user slot |
| cfg_nslots | input | 6 | N for N×64 mode |
| cfg_addr_en | input | 1 | Enable marker word in 56 kbps mode |
| cfg_addr | input | 8 | Address byte of the marker word |
| cfg_sec | input | 8 | Security byte of the marker word |
| tdm_data | output | 1 | TDM serial output |
| tdm_fs | output | 1 | High with bit 0 of slot 0 |
| cfg_err | output | 1 | Invalid slot configuration |

## Verification
The mapping is exercised with five layouts:
- a short N×64 span in the middle of a T1 frame;
- a span covering every T1 slot;
- the widest E1 span, starting at slot 1;
- a 56 kbps slot at the last T1 position;
- a 56 kbps slot with the marker word enabled.

Together these separate errors in the slot range, in the bit order within a slot, in the seventh/eighth bit split, and in the marker word index. Three invalid layouts (an overrun of the frame, E1 slot 0, and N=0) must yield an all-ones line with the error flag set. In these layouts nothing is drained, so the FIFO fills and the source is seen to stall at exactly DEPTH bits. Each run first withholds the source one bit short of the prefill level. This shows that no data leaks onto the line before the threshold is reached.

// File: rtl/s2t_pkg.sv
package s2t_pkg;
  localparam int SLOT_W   = 5;
  localparam int BIT_W    = 3;
  localparam int T1_SLOTS = 24;
  localparam int E1_SLOTS = 32;

  typedef enum logic [1:0] {
    POS_IDLE = 2'd0,
    POS_USER = 2'd1,
    POS_MARK = 2'd2
  } pos_kind_e;

  function automatic logic [SLOT_W+1:0] frame_slots(input logic e1);
    return e1 ? (SLOT_W+2)'(E1_SLOTS) : (SLOT_W+2)'(T1_SLOTS);
  endfunction
endpackage

// File: rtl/s2t_sync.sv
module s2t_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/s2t_cdc_fifo.sv
module s2t_cdc_fifo #(
  parameter int DEPTH = 16
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic              wr_bit,
  output logic              full,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  output logic              rd_bit,
  output logic              empty,
  output logic [$clog2(DEPTH):0] level
);
  localparam int AW = $clog2(DEPTH);

  logic [DEPTH-1:0] mem;
  logic [AW:0] wbin, wgray, wbin_nxt, rq_gray;
  logic [AW:0] rbin, rgray, rbin_nxt, wq_gray, wq_bin;
  logic        do_wr, do_rd;

  assign do_wr    = wr_en && !full;
  assign do_rd    = rd_en && !empty;
  assign wbin_nxt = wbin + (AW+1)'(do_wr);
  assign rbin_nxt = rbin + (AW+1)'(do_rd);

  // write domain
  always_ff @(posedge wclk) begin
    if (do_wr) mem[wbin[AW-1:0]] <= wr_bit;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  s2t_sync #(.W(AW+1)) u_rptr_sync (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rq_gray)
  );

  assign full = (wgray == {~rq_gray[AW:AW-1], rq_gray[AW-2:0]});

  // read domain
  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  s2t_sync #(.W(AW+1)) u_wptr_sync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wq_gray)
  );

  always_comb begin
    wq_bin[AW] = wq_gray[AW];
    for (int i = AW - 1; i >= 0; i--) wq_bin[i] = wq_bin[i+1] ^ wq_gray[i];
  end

  assign empty  = (rgray == wq_gray);
  assign level  = wq_bin - rbin;
  assign rd_bit = mem[rbin[AW-1:0]];

  // R9
  no_underrun_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_en |-> !empty);
  // R9
  level_bound_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    level <= (AW+1)'(DEPTH));
  // R9
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/s2t_slot_map.sv
module s2t_slot_map
  import s2t_pkg::*;
(
  input  logic              e1,
  input  logic              rate56,
  input  logic [SLOT_W-1:0] start,
  input  logic [5:0]        nslots,
  input  logic [SLOT_W-1:0] slot,
  input  logic [BIT_W-1:0]  bidx,
  output pos_kind_e         kind,
  output logic [SLOT_W-1:0] last_slot,
  output logic              err
);
  logic [SLOT_W+1:0] fslots, span, end_ex;

  always_comb begin
    fslots    = frame_slots(e1);
    last_slot = SLOT_W'(fslots - 1'b1);
    span      = rate56 ? (SLOT_W+2)'(1) : (SLOT_W+2)'(nslots);
    end_ex    = (SLOT_W+2)'(start) + span;
    err       = (!rate56 && nslots == '0) || (e1 && start == '0) || (end_ex > fslots);
    kind      = POS_IDLE;
    if (!err) begin
      if (rate56) begin
        if (slot == start) kind = (bidx == 3'd7) ? POS_MARK : POS_USER;
      end else if (slot >= start && (SLOT_W+2)'(slot) < end_ex) begin
        kind = POS_USER;
      end
    end
  end
endmodule

// File: rtl/s2t_inserter.sv
module s2t_inserter
  import s2t_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8,
  parameter int SEC_W  = 8
) (
  input  logic              if_clk,
  input  logic              if_rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic              tdm_clk,
  input  logic              tdm_rst_n,
  input  logic              cfg_e1,
  input  logic              cfg_rate56,
  input  logic [4:0]        cfg_start,
  input  logic [5:0]        cfg_nslots,
  input  logic              cfg_addr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [SEC_W-1:0]  cfg_sec,
  output logic              tdm_data,
  output logic              tdm_fs,
  output logic              cfg_err
);
  localparam int AW       = $clog2(DEPTH);
  localparam int HALF     = DEPTH / 2;
  localparam int WORD_LEN = ADDR_W + SEC_W;
  localparam int TAG_W    = $clog2(WORD_LEN);

  logic              full, empty, rd_en, rd_bit, started, nxt_bit;
  logic [AW:0]       level;
  logic [SLOT_W-1:0] slot_q, last_slot;
  logic [BIT_W-1:0]  bit_q;
  logic [TAG_W-1:0]  tag_q;
  logic [WORD_LEN-1:0] word;
  pos_kind_e         kind;

  assign in_ready = !full;
  assign word     = {cfg_addr, cfg_sec};

  s2t_cdc_fifo #(.DEPTH(DEPTH)) u_fifo (
    .wclk(if_clk), .wrst_n(if_rst_n), .wr_en(in_valid), .wr_bit(in_bit), .full(full),
    .rclk(tdm_clk), .rrst_n(tdm_rst_n), .rd_en(rd_en), .rd_bit(rd_bit),
    .empty(empty), .level(level)
  );

  s2t_slot_map u_map (
    .e1(cfg_e1), .rate56(cfg_rate56), .start(cfg_start), .nslots(cfg_nslots),
    .slot(slot_q), .bidx(bit_q), .kind(kind), .last_slot(last_slot), .err(cfg_err)
  );

  always_comb begin
    rd_en   = (kind == POS_USER) && started && !empty;
    nxt_bit = 1'b1;
    case (kind)
      POS_USER: nxt_bit = rd_en ? rd_bit : 1'b1;
      POS_MARK: nxt_bit = cfg_addr_en ? word[TAG_W'(WORD_LEN - 1) - tag_q] : 1'b1;
      default:  nxt_bit = 1'b1;
    endcase
  end

  always_ff @(posedge tdm_clk or negedge tdm_rst_n) begin
    if (!tdm_rst_n) begin
      bit_q    <= '0;
      slot_q   <= '0;
      tag_q    <= '0;
      started  <= 1'b0;
      tdm_data <= 1'b1;
      tdm_fs   <= 1'b0;
    end else begin
      bit_q    <= bit_q + 1'b1;
      if (bit_q == 3'd7) begin
        if (slot_q == last_slot) begin
          slot_q <= '0;
          tag_q  <= (tag_q == TAG_W'(WORD_LEN - 1)) ? '0 : tag_q + 1'b1;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
      started  <= started || (level >= (AW+1)'(HALF));
      tdm_fs   <= (slot_q == '0) && (bit_q == '0);
      tdm_data <= nxt_bit;
    end
  end

  // R5
  err_idle_chk: assert property (@(posedge tdm_clk) disable iff (!tdm_rst_n)
    cfg_err |=> tdm_data);
  // R1
  fs_single_chk: assert property (@(posedge tdm_clk) disable iff (!tdm_rst_n)
    tdm_fs |=> !tdm_fs);
  // R8
  prefill_hold_chk: assert property (@(posedge tdm_clk) disable iff (!tdm_rst_n)
    !started |=> level >= $past(level));
endmodule

// File: tb/s2t_inserter_tb.sv
module s2t_inserter_tb;
  localparam int TDM_PERIOD = 10;
  localparam int IF_PERIOD  = 8;
  localparam int DEPTH      = 16;

  logic if_clk = 0, tdm_clk = 0, if_rst_n = 0, tdm_rst_n = 0;
  logic in_valid = 0, in_bit = 0, in_ready;
  logic cfg_e1 = 0, cfg_rate56 = 0, cfg_addr_en = 0;
  logic [4:0] cfg_start = 0;
  logic [5:0] cfg_nslots = 1;
  logic [7:0] cfg_addr = 0, cfg_sec = 0;
  logic tdm_data, tdm_fs, cfg_err;

  int vectors = 0, errors = 0, accepted = 0;
  bit stop = 0, hold_done = 0;
  bit q[$];

  always #(IF_PERIOD / 2) if_clk = ~if_clk;
  always #(TDM_PERIOD / 2) tdm_clk = ~tdm_clk;

  s2t_inserter #(.DEPTH(DEPTH)) u_dut (
    .if_clk(if_clk), .if_rst_n(if_rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .tdm_clk(tdm_clk), .tdm_rst_n(tdm_rst_n), .cfg_e1(cfg_e1),
    .cfg_rate56(cfg_rate56), .cfg_start(cfg_start), .cfg_nslots(cfg_nslots),
    .cfg_addr_en(cfg_addr_en), .cfg_addr(cfg_addr), .cfg_sec(cfg_sec),
    .tdm_data(tdm_data), .tdm_fs(tdm_fs), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: scoreboard producer
  task automatic drive();
    logic [7:0] lf = 8'hE1;
    bit pending = 0;
    logic cur = 1'b0;
    while (!stop) begin
      @(negedge if_clk);
      if (stop) break;
      if (accepted == DEPTH / 2 - 1 && !hold_done) begin
        in_valid = 0;
        continue;
      end
      if (!pending && accepted > 0) begin
        cur = lf[7];
        lf  = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      end
      in_valid = 1;
      in_bit   = cur;
      if (in_ready) begin
        q.push_back(cur);
        accepted++;
        pending = 0;
      end else begin
        pending = 1;
      end
    end
    in_valid = 0;
  endtask

  // monitor: scoreboard consumer
  task automatic monitor(input int nfr, input bit err);
    int frames = 0, pos = 0, fbits, slot, b, k;
    bit seen = 0, exp;
    string req;
    fbits = (cfg_e1 ? 32 : 24) * 8;
    while (1) begin
      @(negedge tdm_clk);
      if (tdm_fs) begin
        if (frames > 0) check(pos == fbits - 1, "R1", "frame length-1", pos, fbits - 1);
        frames++;
        pos = 0;
      end else begin
        pos++;
      end
      if (frames == 0) continue;
      if (frames > nfr) break;
      if (pos >= fbits) begin
        check(0, "R1", "missing fs at position", pos, fbits - 1);
        pos = 0;
      end
      slot = pos / 8; b = pos % 8; k = frames - 1;
      if (err) begin
        check(tdm_data == 1, "R5", "bit under cfg error", tdm_data, 1);
      end else if (cfg_rate56 ? (slot == cfg_start && b < 7)
                              : (slot >= cfg_start && slot < cfg_start + cfg_nslots)) begin
        req = cfg_rate56 ? "R6" : "R2";
        if (!seen && tdm_data == 0) begin
          seen = 1;
          check(hold_done, "R8", "data before prefill level", 0, 1);
        end
        if (seen) begin
          if (q.size() == 0) begin
            check(0, "R9", "output with no bit queued", tdm_data, 1);
          end else begin
            exp = q.pop_front();
            check(tdm_data == exp, req, "user bit", tdm_data, exp);
          end
        end else begin
          check(tdm_data == 1, "R8", "user slot before start", tdm_data, 1);
        end
      end else if (cfg_rate56 && slot == cfg_start) begin
        exp = cfg_addr_en ? {cfg_addr, cfg_sec}[15 - (k % 16)] : 1'b1;
        check(tdm_data == exp, cfg_addr_en ? "R7" : "R6", "marker bit", tdm_data, exp);
      end else begin
        check(tdm_data == 1, (cfg_e1 && slot == 0) ? "R4" : "R3", "idle bit", tdm_data, 1);
      end
    end
    if (!err) check(seen, "R8", "stream started after prefill", seen, 1);
    stop = 1;
  endtask

  task automatic run(input bit e1, input bit r56, input int st, input int n,
                     input bit aen, input int nfr, input bit err, input string req);
    cfg_e1 = e1; cfg_rate56 = r56; cfg_start = 5'(st); cfg_nslots = 6'(n);
    cfg_addr_en = aen; cfg_addr = 8'hA5; cfg_sec = 8'h3C;
    if_rst_n = 0; tdm_rst_n = 0;
    q.delete(); accepted = 0; stop = 0; hold_done = 0; in_valid = 0;
    repeat (4) @(negedge tdm_clk);
    check(tdm_data == 1, "R3", "data in reset", tdm_data, 1);
    check(tdm_fs == 0, "R3", "fs in reset", tdm_fs, 0);
    check(in_ready == 1, "R9", "ready in reset", in_ready, 1);
    check(cfg_err == err, req, "cfg_err", cfg_err, err);
    @(negedge if_clk) if_rst_n = 1;
    @(negedge tdm_clk) tdm_rst_n = 1;
    fork
      drive();
      monitor(nfr, err);
      begin
        #(3 * (e1 ? 256 : 192) * TDM_PERIOD);
        hold_done = 1;
      end
    join
    if (err) begin
      check(accepted == DEPTH, "R9", "bits taken with no drain", accepted, DEPTH);
      check(in_ready == 0, "R9", "ready when full", in_ready, 0);
    end
  endtask

  initial begin
    run(0, 0, 3, 4, 0, 9, 0, "R2");    // R2 mid-frame span
    run(0, 0, 0, 24, 0, 8, 0, "R2");   // R2 full T1 span
    run(1, 0, 1, 31, 0, 8, 0, "R4");   // R4 widest E1 span
    run(0, 1, 23, 1, 0, 9, 0, "R6");   // R6 56k at last slot
    run(1, 1, 5, 1, 1, 21, 0, "R7");   // R7 marker word
    run(0, 0, 20, 5, 0, 6, 1, "R5");   // R5 overrun
    run(1, 0, 0, 2, 0, 6, 1, "R4");    // R4 E1 slot 0
    run(0, 0, 2, 0, 0, 6, 1, "R5");    // R5 N=0
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge tdm_clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule